// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic-logic unit. It is built from a row of one-bit slices. A single ripple carry chain joins them. Two operand words and a four-bit operation code go in. One result word, a zero flag and a signed-overflow flag come out, all in the same cycle. The supported operations are bitwise AND, OR and NOR, two's-complement add and subtract, and a signed set-if-less-than compare.

The operation code is not an arbitrary number. It is a set of control fields:
- One bit inverts operand A on its way into each slice.
- One bit inverts operand B and also supplies the carry-in of the lowest slice.
- A two-bit field picks the output of each slice: the AND path, the OR path, the adder sum, or the "less" input.

Subtraction is therefore B-inversion plus a carry-in of one. NOR is the AND path applied to both inverted operands.

For the compare, only the lowest slice takes its "less" input from the sign of the difference. That sign is produced by the top slice. Every other slice receives zero. The block is meant to sit in a datapath where a decoder supplies the code and a register stage captures the outputs.

Top module: `bitslice_alu`

## Requirements
- R1: Code 0000 gives result = A AND B.
- R2: Code 0001 gives result = A OR B.
- R3: Code 0010 gives result = (A + B) modulo 2^WIDTH.
- R4: Code 0110 gives result = (A - B) modulo 2^WIDTH.
- R5: Code 0111 gives result bit 0 = bit WIDTH-1 of (A - B) modulo 2^WIDTH, and all higher result bits = 0.
- R6: Code 1100 gives result = NOT (A OR B).
- R7: The zero flag is 1 exactly when every result bit is 0, whatever the code.
- R8: For codes whose low two bits are 10 (add 0010, subtract 0110), the overflow flag is 1 exactly when the signed two's-complement result does not fit in WIDTH bits. For every other code it is 0.
- R9: Set-if-less-than applies no overflow correction. For example, A = most negative value and B = 1 gives result 0, and A = most positive value and B = -1 gives result 1.
- R10: Every 4-bit code follows the same field rule:
  - bit 3 inverts A;
  - bit 2 inverts B and sets the lowest carry-in to 1;
  - bits 1:0 select the slice output: 00 = AND of the conditioned operands, 01 = OR of them, 10 = sum, 11 = "less" (the sign of the sum, placed in bit 0).
  
  This holds for codes outside the six named ones as well. For example, 0100 gives A AND NOT B, and 1010 gives NOT A + B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| op_code_i | input | 4 | Operation code: bit 3 inverts A, bit 2 negates B, bits 1:0 select the slice output |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when the result word is all zeros |
| overflow_o | output | 1 | Signed overflow for add and subtract codes |

## Verification
The named operations are driven with every pairing of six corner operands: zero, all ones, the most negative value, the most positive value, one, and an alternating pattern. Each operation is also driven with a batch of pseudo-random pairs. The corner pairings separate a correct carry chain from one that drops the carry-in or the top carry. They also separate a correct overflow rule from one that ignores either operand sign. Targeted pairs such as most-negative minus one and most-positive minus all-ones tell a raw sign compare apart from a corrected one. Unnamed codes are checked against the field rule, which shows that the inversion and select fields act independently of each other.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Purpose : shared control types and named operation codes for the bit-sliced ALU.
// Assumes : the 4-bit code is split into invert-A, negate-B and a 2-bit output pick.
package alu_pkg;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } pick_e;

    typedef struct packed {
        logic  inv_a;
        logic  neg_b;
        pick_e pick;
    } alu_ctl_t;

    localparam logic [3:0] OPC_AND = 4'b0000;
    localparam logic [3:0] OPC_OR  = 4'b0001;
    localparam logic [3:0] OPC_ADD = 4'b0010;
    localparam logic [3:0] OPC_SUB = 4'b0110;
    localparam logic [3:0] OPC_SLT = 4'b0111;
    localparam logic [3:0] OPC_NOR = 4'b1100;

endpackage

// File: rtl/alu_decode.sv
// Module alu_decode
// Purpose : splits the operation code into per-slice control fields.
// Assumes : every 4-bit value is legal; the fields apply independently.
module alu_decode
    import alu_pkg::*;
(
    input  logic [3:0] op_code_i,
    output alu_ctl_t   ctl_o
);

    // Map code bits onto the control fields.
    always_comb begin
        ctl_o.inv_a = op_code_i[3];
        ctl_o.neg_b = op_code_i[2];
        ctl_o.pick  = pick_e'(op_code_i[1:0]);
    end

endmodule

// File: rtl/alu_carry_chain.sv
// Module alu_carry_chain
// Purpose : ripple carry network across all slices.
// Assumes : operands are already conditioned (inverted) by the slices;
//           carry_o[0] is the chain input, carry_o[WIDTH] the final carry.
module alu_carry_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] ae_i,
    input  logic [WIDTH-1:0] be_i,
    input  logic             cin_i,
    output logic [WIDTH:0]   carry_o
);

    // Ripple the carry from bit 0 upward using generate/propagate terms.
    always_comb begin
        logic [WIDTH:0] c;
        c[0] = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            c[i+1] = (ae_i[i] & be_i[i]) | ((ae_i[i] ^ be_i[i]) & c[i]);
        end
        carry_o = c;
    end

endmodule

// File: rtl/alu_slice.sv
// Module alu_slice
// Purpose : one bit of the ALU - operand conditioning, sum bit and output pick.
// Assumes : carries come from the shared chain; IS_TOP marks the sign slice,
//           which alone reports its sum as "set" and its overflow term.
module alu_slice
    import alu_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic  a_i,
    input  logic  b_i,
    input  logic  inv_a_i,
    input  logic  neg_b_i,
    input  logic  cin_i,
    input  logic  cout_i,
    input  logic  less_i,
    input  pick_e pick_i,
    output logic  ae_o,
    output logic  be_o,
    output logic  res_o,
    output logic  set_o,
    output logic  ovf_o
);

    logic sum;

    // Condition operands and form the sum bit.
    always_comb begin
        ae_o = a_i ^ inv_a_i;
        be_o = b_i ^ neg_b_i;
        sum  = ae_o ^ be_o ^ cin_i;
    end

    // Pick this slice's output from the four paths.
    always_comb begin
        unique case (pick_i)
            PICK_AND:  res_o = ae_o & be_o;
            PICK_OR:   res_o = ae_o | be_o;
            PICK_SUM:  res_o = sum;
            PICK_LESS: res_o = less_i;
            default:   res_o = 1'b0;
        endcase
    end

    // Sign and overflow terms, live only in the top slice.
    always_comb begin
        set_o = IS_TOP & sum;
        ovf_o = IS_TOP & (cin_i ^ cout_i);
    end

endmodule

// File: rtl/alu_flags.sv
// Module alu_flags
// Purpose : zero detect over the result word and gating of the overflow flag.
// Assumes : ovf_bits_i is zero except in the top slice position.
module alu_flags
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  pick_e            pick_i,
    input  logic [WIDTH-1:0] ovf_bits_i,
    output logic             zero_o,
    output logic             ovf_o
);

    // Reduce the result and qualify overflow by the arithmetic pick.
    always_comb begin
        zero_o = ~|res_i;
        ovf_o  = (pick_i == PICK_SUM) & (|ovf_bits_i);
    end

endmodule

// File: rtl/bitslice_alu.sv
// Module bitslice_alu
// Purpose : WIDTH-bit combinational ALU made of one-bit slices on a ripple chain.
// Assumes : no clock or state; outputs settle from inputs within the cycle.
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [3:0]       op_code_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] ae_w;
    logic [WIDTH-1:0] be_w;
    logic [WIDTH:0]   carry_w;
    logic [WIDTH-1:0] less_w;
    logic [WIDTH-1:0] set_w;
    logic [WIDTH-1:0] ovf_w;
    logic [WIDTH-1:0] res_w;
    logic             set_bit;

    alu_decode u_decode (
        .op_code_i (op_code_i),
        .ctl_o     (ctl)
    );

    alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .ae_i    (ae_w),
        .be_i    (be_w),
        .cin_i   (ctl.neg_b),
        .carry_o (carry_w)
    );

    // Only the top slice drives a nonzero set term.
    always_comb set_bit = |set_w;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == 0) begin : g_lsb_less
            assign less_w[i] = set_bit;
        end else begin : g_zero_less
            assign less_w[i] = 1'b0;
        end

        alu_slice #(.IS_TOP(i == MSB)) u_slice (
            .a_i     (opa_i[i]),
            .b_i     (opb_i[i]),
            .inv_a_i (ctl.inv_a),
            .neg_b_i (ctl.neg_b),
            .cin_i   (carry_w[i]),
            .cout_i  (carry_w[i+1]),
            .less_i  (less_w[i]),
            .pick_i  (ctl.pick),
            .ae_o    (ae_w[i]),
            .be_o    (be_w[i]),
            .res_o   (res_w[i]),
            .set_o   (set_w[i]),
            .ovf_o   (ovf_w[i])
        );
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i      (res_w),
        .pick_i     (ctl.pick),
        .ovf_bits_i (ovf_w),
        .zero_o     (zero_o),
        .ovf_o      (overflow_o)
    );

    // Drive the result word out.
    always_comb result_o = res_w;

    // Guard the slice row against word-level arithmetic and logic.
    always_comb begin
        if (op_code_i == OPC_AND) begin
            // R1
            and_op_chk: assert (result_o == (opa_i & opb_i))
                else $error("and result mismatch");
        end
        if (op_code_i == OPC_ADD) begin
            // R3
            add_op_chk: assert (result_o == opa_i + opb_i)
                else $error("add result mismatch");
        end
        if (op_code_i == OPC_SUB) begin
            // R4
            sub_op_chk: assert (result_o == opa_i - opb_i)
                else $error("sub result mismatch");
        end
        if (op_code_i == OPC_SLT) begin
            // R5
            slt_upper_chk: assert (result_o[WIDTH-1:1] == '0)
                else $error("slt upper bits nonzero");
        end
        if (op_code_i[1:0] != 2'b10) begin
            // R8
            no_overflow_chk: assert (!overflow_o)
                else $error("overflow on non-arithmetic code");
        end
        if (op_code_i == OPC_NOR) begin
            // R6
            nor_op_chk: assert (result_o == ~(opa_i | opb_i))
                else $error("nor result mismatch");
        end
    end

endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;

    localparam int  W          = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb, res;
    logic [3:0]   code;
    logic         zero, ovf;
    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;

    localparam logic [W-1:0] MIN_S = 32'h8000_0000;
    localparam logic [W-1:0] MAX_S = 32'h7FFF_FFFF;
    localparam logic [W-1:0] ONES  = 32'hFFFF_FFFF;

    logic [W-1:0] corners [6];

    bitslice_alu #(.WIDTH(W)) dut (
        .opa_i      (opa),
        .opb_i      (opb),
        .op_code_i  (code),
        .result_o   (res),
        .zero_o     (zero),
        .overflow_o (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: code=%b a=%h b=%h actual=%h expected=%h", req, code, opa, opb, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        code = c; opa = a; opb = b;
        @(negedge clk);
    endtask

    // Generic field-rule model (R10): conditioned operands, carry-in, pick.
    function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] ai, bi, s;
        ai = c[3] ? ~a : a;
        bi = c[2] ? ~b : b;
        s  = ai + bi + {31'b0, c[2]};
        case (c[1:0])
            2'b00:   return ai & bi;
            2'b01:   return ai | bi;
            2'b10:   return s;
            default: return {31'b0, s[W-1]};
        endcase
    endfunction

    task automatic test_reset_state();
        apply(4'b0000, '0, '0);
        check("R7 reset-state result", res, '0);
        check("R7 reset-state zero", {31'b0, zero}, 1);
        check("R8 reset-state overflow", {31'b0, ovf}, 0);
    endtask

    task automatic test_logic_ops();
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                apply(4'b0000, corners[i], corners[j]);
                check("R1 and", res, corners[i] & corners[j]);
                check("R8 and no overflow", {31'b0, ovf}, 0);
                apply(4'b0001, corners[i], corners[j]);
                check("R2 or", res, corners[i] | corners[j]);
                apply(4'b1100, corners[i], corners[j]);
                check("R6 nor", res, ~(corners[i] | corners[j]));
                check("R7 zero on nor", {31'b0, zero}, {31'b0, ((corners[i] | corners[j]) == ONES)});
            end
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] a, b;
            a = $urandom; b = $urandom;
            apply(4'b0000, a, b); check("R1 and random", res, a & b);
            apply(4'b0001, a, b); check("R2 or random", res, a | b);
            apply(4'b1100, a, b); check("R6 nor random", res, ~(a | b));
        end
    endtask

    task automatic test_add_sub();
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                logic [W-1:0] a, b, s, d;
                a = corners[i]; b = corners[j];
                s = a + b; d = a - b;
                apply(4'b0010, a, b);
                check("R3 add", res, s);
                check("R8 add overflow", {31'b0, ovf}, {31'b0, (a[W-1] == b[W-1]) && (s[W-1] != a[W-1])});
                check("R7 zero on add", {31'b0, zero}, {31'b0, (s == '0)});
                apply(4'b0110, a, b);
                check("R4 sub", res, d);
                check("R8 sub overflow", {31'b0, ovf}, {31'b0, (a[W-1] != b[W-1]) && (d[W-1] != a[W-1])});
                check("R7 zero on sub", {31'b0, zero}, {31'b0, (a == b)});
            end
        apply(4'b0010, MAX_S, 32'd1);
        check("R8 max+1 overflow", {31'b0, ovf}, 1);
        apply(4'b0110, MIN_S, 32'd1);
        check("R8 min-1 overflow", {31'b0, ovf}, 1);
        check("R4 min-1 wraps", res, MAX_S);
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] a, b;
            a = $urandom; b = $urandom;
            apply(4'b0010, a, b); check("R3 add random", res, a + b);
            apply(4'b0110, a, b); check("R4 sub random", res, a - b);
        end
    endtask

    task automatic test_slt();
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                logic [W-1:0] d;
                d = corners[i] - corners[j];
                apply(4'b0111, corners[i], corners[j]);
                check("R5 slt", res, {31'b0, d[W-1]});
                check("R8 slt no overflow", {31'b0, ovf}, 0);
            end
        apply(4'b0111, MIN_S, 32'd1);
        check("R9 slt min vs 1 raw sign", res, 0);
        apply(4'b0111, MAX_S, ONES);
        check("R9 slt max vs -1 raw sign", res, 1);
        apply(4'b0111, 32'd5, 32'd5);
        check("R7 zero on equal slt", {31'b0, zero}, 1);
        apply(4'b0111, ONES, 32'd0);
        check("R5 slt -1 vs 0", res, 1);
        check("R7 zero clear on slt true", {31'b0, zero}, 0);
    endtask

    task automatic test_other_codes();
        logic [3:0] extra [6];
        extra = '{4'b0100, 4'b1101, 4'b1010, 4'b0011, 4'b1000, 4'b1110};
        for (int c = 0; c < 6; c++)
            for (int k = 0; k < 12; k++) begin
                logic [W-1:0] a, b;
                a = (k < 6) ? corners[k] : $urandom;
                b = (k < 6) ? corners[5 - k] : $urandom;
                apply(extra[c], a, b);
                check("R10 field rule", res, model(extra[c], a, b));
            end
        apply(4'b0100, 32'hF0F0_FFFF, 32'h0F0F_00FF);
        check("R10 0100 is a and not b", res, 32'hF0F0_FF00);
        apply(4'b1010, 32'd3, 32'd10);
        check("R10 1010 is not a plus b", res, 32'd6);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=%0d cycles expected=below %0d", cyc, WATCHDOG);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        corners = '{32'h0, ONES, MIN_S, MAX_S, 32'h1, 32'hA5A5_5A5A};
        code = '0; opa = '0; opb = '0;
        void'($urandom(32'd1234));
        test_reset_state();
        test_logic_ops();
        test_add_sub();
        test_slt();
        test_other_codes();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule